// File: doc/BRIEF.md
# Byte/Word Selectable Memory Port

This block sits between a processor-style bus and a word-organised storage array. A width-select input chooses between full 16-bit accesses and 8-bit accesses. In 8-bit mode the most significant data pin stops carrying data. It becomes an extra address input that picks the lower or upper half of the addressed word, so the array is seen as twice as many bytes. The port produces a per-pin drive-enable vector, so the pad ring can float any lane that must not be driven.

Reads are synchronous. Address, width and lane select are captured on a clock edge, and the selected data and the drive enables appear together after that edge. Chip-select and output-enable are both active low, and both must be asserted for any pin to be driven. An identifier mode returns a manufacturer code or a device code in place of array data. The identifier values are parameters. Writes use the same width rules and are blocked while identifier mode is selected.

Top module: `byte_word_port`

## Requirements
- R1: With `word_sel` high and `cs_n`, `oe_n` low at a clock edge, after that edge `dq_oe` is 16'hFFFF and `dq_out` is the full 16-bit word stored at `addr`.
- R2: With `word_sel` low and the port selected and enabled at an edge, after that edge `dq_oe[7:0]` is all ones and `dq_oe[15:8]` is all zeros, so lines 8 to 14 float and line 15 is an input.
- R3: In byte mode `dq_in[15]` is the lowest byte-address bit: 0 returns word bits [7:0] and 1 returns word bits [15:8] on `dq_out[7:0]`.
- R4: If `cs_n` or `oe_n` is high at an edge, `dq_oe` is all zeros after that edge.
- R5: `dq_oe` is registered: after a change of `cs_n` or `oe_n`, it keeps its old value until the next rising clock edge.
- R6: With `id_mode` high in word mode, `addr[0]`=0 returns the manufacturer code zero-extended to 16 bits (default 16'h0089), and `addr[0]`=1 returns the device code (default 16'h4470).
- R7: With `id_mode` high in byte mode, only the low byte of the selected identifier is returned on `dq_out[7:0]`, and `dq_in[15]` has no effect.
- R8: With `cs_n` and `we_n` low, `id_mode` low and `word_sel` high at an edge, `dq_in[15:0]` is stored at `addr`.
- R9: In byte mode a write stores `dq_in[7:0]` into the byte chosen by `dq_in[15]` (0 low, 1 high), and the other byte of the word is unchanged.
- R10: A write attempted while `id_mode` is high leaves the array unchanged.
- R11: The array holds 2^`ADDR_W` words, which is 2^(`ADDR_W`+1) bytes in byte mode. `ADDR_W`=18 gives 262,144 words, or 524,288 bytes. Every word address is reachable.
- R12: While `rst_n` is low at an edge, `dq_oe` is all zeros after that edge.
- R13: A read and a write to the same address at the same edge return the contents held before the write. The new data is returned from the following edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| word_sel | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| id_mode | input | 1 | 1 = return identifier codes instead of array data |
| addr | input | ADDR_W | Word address; bit 0 also picks the identifier |
| dq_in | input | 16 | Data pins as seen by the port; bit 15 is the byte address in byte mode |
| dq_out | output | 16 | Value to drive onto the data pins |
| dq_oe | output | 16 | Per-pin drive enable; 0 means the pin floats |

## Verification
A read and a write can land on the same edge at the same word, and a byte-mode access can change its lane select at the same edge as a width change. The bench asserts `we_n` together with `oe_n` on one word. It expects the previous contents after that edge and the new word one edge later. It also alternates the byte-select pin across a complete byte-mode sweep immediately after a full word-mode sweep, and compares every lane against bytes derived arithmetically from the written pattern.

// File: rtl/bwp_pkg.sv
// Shared types for the byte/word memory port.
// Assumes a 16-bit data path split into two 8-bit lanes.
package bwp_pkg;

    // Byte lane chosen by the byte-address bit in 8-bit mode
    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    // Read-side control captured on each clock edge
    typedef struct packed {
        logic  drive;   // pins may be driven
        logic  wide;    // 16-bit access
        lane_e lane;    // byte lane in 8-bit access
        logic  id_sel;  // identifier substitution
        logic  id_dev;  // 1 = device code, 0 = manufacturer code
    } rd_ctl_t;

endpackage

// File: rtl/bwp_array.sv
// Synchronous word array with per-lane write enables.
// Assumes DATA_W is a multiple of 8; read data is registered every cycle,
// so a read on the same edge as a write to that word returns the old word.
module bwp_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [DATA_W/8-1:0] lane_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] mem [DEPTH];

    // Lane-masked write and registered read of the addressed word
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (lane_we[l]) begin
                    mem[addr][l*8 +: 8] <= wdata[l*8 +: 8];
                end
            end
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/bwp_ctl.sv
// Captures read-side control on each clock edge so that pin drive, lane
// choice and identifier substitution line up with the registered array word.
// Assumes synchronous active-low reset; reset leaves all pins floating.
module bwp_ctl
    import bwp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cs_n,
    input  logic    oe_n,
    input  logic    word_sel,
    input  logic    id_mode,
    input  logic    addr_lsb,
    input  logic    byte_bit,
    output rd_ctl_t ctl_q
);
    rd_ctl_t ctl_d;

    // Next control word from the bus pins
    always_comb begin
        ctl_d.drive  = ~cs_n & ~oe_n;
        ctl_d.wide   = word_sel;
        ctl_d.lane   = lane_e'(byte_bit);
        ctl_d.id_sel = id_mode;
        ctl_d.id_dev = addr_lsb;
    end

    // Control register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/bwp_lane_mux.sv
// Forms the pin data and per-pin drive enables from the registered word
// and control. Assumes 16 pins: lanes [7:0] always carry data when driven,
// pins [15:8] only in 16-bit mode.
module bwp_lane_mux
    import bwp_pkg::*;
#(
    parameter int          DATA_W = 16,
    parameter logic [7:0]  MFR_ID = 8'h89,
    parameter logic [15:0] DEV_ID = 16'h4470
) (
    input  rd_ctl_t           ctl,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] dq_oe
);
    localparam int BYTE_W = DATA_W / 2;

    logic [DATA_W-1:0] src;
    logic [BYTE_W-1:0] low_byte;

    // Source word: array data or identifier code
    always_comb begin
        if (ctl.id_sel) begin
            src = ctl.id_dev ? DEV_ID : {{(DATA_W-8){1'b0}}, MFR_ID};
        end else begin
            src = word;
        end
    end

    // Byte routing: identifiers always use their low byte in 8-bit mode
    always_comb begin
        if (ctl.id_sel || ctl.lane == LANE_LO) begin
            low_byte = src[BYTE_W-1:0];
        end else begin
            low_byte = src[DATA_W-1:BYTE_W];
        end
    end

    // Output data: full word when wide, otherwise the routed byte
    always_comb begin
        if (ctl.wide) begin
            dq_out = src;
        end else begin
            dq_out = {{BYTE_W{1'b0}}, low_byte};
        end
    end

    // Per-pin drive enables
    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_pin
            if (g < BYTE_W) begin : g_low
                assign dq_oe[g] = ctl.drive;
            end else begin : g_high
                assign dq_oe[g] = ctl.drive & ctl.wide;
            end
        end
    endgenerate

endmodule

// File: rtl/byte_word_port.sv
// Byte/word selectable memory port: 16-bit or 8-bit access to a word array,
// with pin 15 reused as the byte address in 8-bit mode, registered pin drive
// and an identifier read mode. Assumes synchronous active-low reset; the
// array contents are not reset.
module byte_word_port
    import bwp_pkg::*;
#(
    parameter int          ADDR_W = 10,
    parameter logic [7:0]  MFR_ID = 8'h89,
    parameter logic [15:0] DEV_ID = 16'h4470
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              word_sel,
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe
);
    localparam int DATA_W = 16;
    localparam int BYTE_W = DATA_W / 2;
    localparam int LANES  = DATA_W / 8;

    logic              wr_en;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rd_word;
    rd_ctl_t           ctl_q;

    // Write gating and lane selection from the width mode
    always_comb begin
        wr_en = rst_n & ~cs_n & ~we_n & ~id_mode;
        if (word_sel) begin
            wdata   = dq_in;
            lane_we = '1;
        end else begin
            wdata   = {dq_in[BYTE_W-1:0], dq_in[BYTE_W-1:0]};
            lane_we = dq_in[DATA_W-1] ? 2'b10 : 2'b01;
        end
    end

    bwp_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .lane_we (lane_we),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rd_word)
    );

    bwp_ctl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .oe_n     (oe_n),
        .word_sel (word_sel),
        .id_mode  (id_mode),
        .addr_lsb (addr[0]),
        .byte_bit (dq_in[DATA_W-1]),
        .ctl_q    (ctl_q)
    );

    bwp_lane_mux #(
        .DATA_W (DATA_W),
        .MFR_ID (MFR_ID),
        .DEV_ID (DEV_ID)
    ) u_mux (
        .ctl    (ctl_q),
        .word   (rd_word),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

endmodule

// File: rtl/bwp_checker.sv
// Port-level properties of the byte/word port, attached by bind.
// Assumes the registered one-cycle relation between bus pins and outputs.
module bwp_checker #(
    parameter int          ADDR_W = 10,
    parameter logic [7:0]  MFR_ID = 8'h89,
    parameter logic [15:0] DEV_ID = 16'h4470
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              oe_n,
    input logic              word_sel,
    input logic              id_mode,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       dq_in,
    input logic [15:0]       dq_out,
    input logic [15:0]       dq_oe
);
    // R4
    off_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || oe_n) |=> (dq_oe == 16'h0000));

    // R1
    word_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !oe_n && word_sel) |=> (dq_oe == 16'hFFFF));

    // R2
    byte_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !oe_n && !word_sel) |=> (dq_oe == 16'h00FF));

    // R6
    id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !oe_n && id_mode && word_sel && !addr[0])
        |=> (dq_out == {8'h00, MFR_ID}));

    // R6
    id_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !oe_n && id_mode && word_sel && addr[0])
        |=> (dq_out == DEV_ID));

    // R7
    id_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !oe_n && id_mode && !word_sel && addr[0])
        |=> (dq_out[7:0] == DEV_ID[7:0]));

    // R5
    drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(!cs_n && !oe_n) |-> (dq_oe == 16'h0000));

    // R3
    lane_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_mode && !word_sel && dq_in[15]) |=> (dq_out[15:8] == 8'h00));

endmodule

bind byte_word_port bwp_checker #(
    .ADDR_W (ADDR_W),
    .MFR_ID (MFR_ID),
    .DEV_ID (DEV_ID)
) u_bwp_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .word_sel (word_sel),
    .id_mode  (id_mode),
    .addr     (addr),
    .dq_in    (dq_in),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
);

// File: tb/tb_byte_word_port.sv
// Sweeps a 64-word configuration of the byte/word port in both widths,
// with expected data computed from an arithmetic fill pattern.
module tb_byte_word_port;
    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n, cs_n, oe_n, we_n, word_sel, id_mode;
    logic [AW-1:0] addr;
    logic [15:0]   dq_in, dq_out, dq_oe;
    int            checks = 0;
    int            failures = 0;
    logic [15:0]   model [NW];

    always #5 clk = ~clk;

    byte_word_port #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .word_sel(word_sel), .id_mode(id_mode), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [15:0] pat(int a);
        return 16'((a * 16'h0515) ^ 16'hA5C3);
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; id_mode = 1'b0;
    endtask

    // Drive one bus cycle from a falling edge; return at the next falling edge
    task automatic cyc(logic c, logic o, logic w, logic ws, logic id,
                       logic [AW-1:0] a, logic [15:0] d);
        cs_n = c; oe_n = o; we_n = w; word_sel = ws; id_mode = id;
        addr = a; dq_in = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; word_sel = 1'b1; addr = '0; dq_in = '0;
        cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; id_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 reset floats pins", dq_oe, 16'h0000);
        rst_n = 1'b1;
        idle();
        @(negedge clk);

        // R8 word fill of every address
        for (int a = 0; a < NW; a++) begin
            model[a] = pat(a);
            cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, AW'(a), pat(a));
        end

        // R1 / R11 word read sweep
        for (int a = 0; a < NW; a++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(a), 16'h0000);
            chk("R1 word drive", dq_oe, 16'hFFFF);
            chk("R11 word data", dq_out, model[a]);
        end

        // R2 / R3 byte read sweep, lane toggling each access
        for (int a = 0; a < NW; a++) begin
            for (int b = 0; b < 2; b++) begin
                cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(a), {b[0], 15'h0});
                chk("R2 byte drive", dq_oe, 16'h00FF);
                chk("R3 byte data", dq_out[7:0],
                    b ? model[a][15:8] : model[a][7:0]);
            end
        end

        // R4 output disable by either control
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'(3), 16'h0);
        chk("R4 oe_n high", dq_oe, 16'h0000);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, AW'(3), 16'h0);
        chk("R4 cs_n high", dq_oe, 16'h0000);

        // R5 drive waits for the next rising edge
        cs_n = 1'b0; oe_n = 1'b0;
        #4;
        chk("R5 before edge", dq_oe, 16'h0000);
        @(negedge clk);
        chk("R5 after edge", dq_oe, 16'hFFFF);
        oe_n = 1'b1;
        #4;
        chk("R5 hold on release", dq_oe, 16'hFFFF);
        @(negedge clk);
        chk("R5 released", dq_oe, 16'h0000);

        // R6 identifier in word mode
        for (int a = 0; a < 4; a++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, AW'(a * 5), 16'h0);
            chk("R6 id word", dq_out, ((a * 5) % 2) ? 16'h4470 : 16'h0089);
        end

        // R7 identifier in byte mode, byte bit ignored
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, AW'(a), {b[0], 15'h0});
                chk("R7 id byte", dq_out[7:0], a ? 8'h70 : 8'h89);
                chk("R7 id byte drive", dq_oe, 16'h00FF);
            end
        end

        // R9 byte writes into each lane, other lane kept
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(5), 16'h803C);
        model[5][15:8] = 8'h3C;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(6), 16'h00E1);
        model[6][7:0] = 8'hE1;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(5), 16'h0);
        chk("R9 high lane write", dq_out, model[5]);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(6), 16'h0);
        chk("R9 low lane write", dq_out, model[6]);

        // R10 write blocked in identifier mode
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, AW'(7), 16'h1234);
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(7), 16'h0);
        chk("R10 id write ignored", dq_out, model[7]);

        // R13 read and write of one word on the same edge
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, AW'(9), 16'hBEEF);
        chk("R13 old data on collision", dq_out, model[9]);
        model[9] = 16'hBEEF;
        cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(9), 16'h0);
        chk("R13 new data next edge", dq_out, model[9]);

        // R11 top word in byte mode, high lane
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(NW - 1), 16'h8000);
        chk("R11 last byte", dq_out[7:0], model[NW-1][15:8]);

        idle();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule